// File: doc/BRIEF.md
# Lockable ROM Page Mapper

This block sits between the CPU bus and a paged cartridge ROM made of 16 KB pages, at most 32 of them. It holds the upper-bank select written through an I/O port and turns it into a 5-bit physical page number. The translation is not linear. Any select value with bit 7 clear maps to a fixed page. The exception is a select value equal to the active disk code, which maps to a second fixed page. Any select value with bit 7 set passes its low five bits through unchanged. For every CPU memory address the block reports whether the ROM answers, which physical page it answers with, whether the memory-mapped register page is selected, and whether a memory write should reach the RAM underneath.

A secondary low-bank mapping register controls where the low ROM bank sits and which of the first eight pages it shows. It can also switch on the register page at 4000h–7FFFh. This register is hidden behind an unlock. A fixed sequence of bytes must be written to a dedicated I/O port before it becomes reachable. Until then, a write aimed at it is taken as a legacy mode-register write, and the low bank stays at 0000h showing page 0.

The legacy mode register still carries separate disable bits for the low and high ROM. An external disable input suppresses ROM wherever it is mapped.

Top module: `rom_page_mapper`

## Requirements
- R1: With upper select bit 7 clear, a high-bank (C000h–FFFFh) ROM access returns physical page 1. If the select equals the disk code, it returns page 3 instead. The disk code is 0 when `disk_alt` is 0 and 7 when `disk_alt` is 1.
- R2: With upper select bit 7 set, the high-bank physical page equals select bits 4..0. The upper select is written by an I/O write with address bits 15..8 equal to DFh, and it resets to 0.
- R3: The block unlocks after the bytes FFh, 00h, A5h, 5Ah are written in that order to I/O address high byte BCh. A mismatching byte restarts the match, and it counts as the first byte if it equals FFh. Once unlocked the block stays unlocked. A reset locks it again.
- R4: An I/O write to address high byte 7Fh with data bits 7..5 = 101 loads data bits 4..0 into the secondary register, but only when unlocked. When locked, the same write is a legacy mode write, and the secondary register keeps its value.
- R5: When unlocked, secondary bits 4..3 place the low bank. The codes are: 00 at 0000h, 01 at 4000h, 10 at 8000h, and 11 at 0000h with the register page switched on at 4000h–7FFFh. For codes 00 to 10 the register page is off.
- R6: The low bank shows the physical page given by secondary bits 2..0. The secondary register resets to 0.
- R7: While locked, the register page is off and the low bank sits at 0000h showing page 0.
- R8: A legacy mode write (address high byte 7Fh, data bits 7..6 = 10, not taken by R4) sets the low-ROM disable from data bit 2 and the high-ROM disable from data bit 3. Both disables reset to 0. `ext_rom_dis` suppresses ROM in every bank.
- R9: `ram_we` follows `mem_wr` at every address outside the register page, including addresses currently mapped as ROM. `ram_we` is 0 inside the register page.
- R10: `rom_page` is 0 whenever `rom_sel` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address; bits 15..8 select the I/O port on I/O writes |
| io_wr | input | 1 | I/O write strobe, one cycle per write |
| mem_wr | input | 1 | Memory write strobe |
| cpu_data | input | 8 | CPU write data |
| ext_rom_dis | input | 1 | External ROM disable |
| disk_alt | input | 1 | Disk code select: 0 gives code 0, 1 gives code 7 |
| rom_sel | output | 1 | ROM answers at the current address |
| rom_page | output | 5 | Physical cartridge page |
| reg_page_sel | output | 1 | Register page selected at the current address |
| ram_we | output | 1 | Write reaches RAM |

## Verification
All outputs are combinational from the current address and the registered state. A wrong register value therefore shows up on the first probe after the write that produced it. A stored upper select that is wrong appears as a wrong page at C000h. A wrong secondary value appears as the low bank in the wrong region, a wrong page, or a register page that is on or off when it should not be. A matcher that unlocks too early or too late is exposed by a secondary-register write. If the block is still locked, that write turns into a mode write and disables the high ROM.

// File: rtl/rpm_pkg.sv
package rpm_pkg;

    localparam int PAGE_W     = 5;
    localparam int LOW_PAGE_W = 3;
    localparam int CFG_W      = 5;

    typedef struct packed {
        logic              lo_off;
        logic              hi_off;
        logic [7:0]        upper;
        logic [CFG_W-1:0]  low_cfg;
    } map_regs_t;

    // Upper select to physical page: direct above 127, fixed below,
    // with an alternate fixed page when the select hits the disk code.
    function automatic logic [PAGE_W-1:0] upper_phys(input logic [7:0] sel,
                                                     input logic       disk_alt);
        logic [7:0] dcode;
        dcode = disk_alt ? 8'd7 : 8'd0;
        if (sel[7])
            return sel[PAGE_W-1:0];
        else if (sel == dcode)
            return PAGE_W'(3);
        else
            return PAGE_W'(1);
    endfunction

endpackage

// File: rtl/rpm_unlock.sv
module rpm_unlock #(
    parameter int                  KEY_LEN = 4,
    parameter logic [8*KEY_LEN-1:0] KEY    = 32'hFF00_A55A
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       key_wr,
    input  logic [7:0] key_byte,
    output logic       unlocked
);
    localparam int IW = (KEY_LEN > 2) ? $clog2(KEY_LEN) : 1;
    localparam logic [IW-1:0] LAST = IW'(KEY_LEN - 1);

    typedef struct packed {
        logic          open;
        logic [IW-1:0] idx;
    } st_t;

    st_t st_d, st_q;

    function automatic logic [7:0] key_at(input int i);
        return KEY[8*(KEY_LEN-1-i) +: 8];
    endfunction

    always_comb begin
        st_d = st_q;
        if (key_wr && !st_q.open) begin
            if (key_byte == key_at(int'(st_q.idx))) begin
                if (st_q.idx == LAST) begin
                    st_d.open = 1'b1;
                    st_d.idx  = '0;
                end else begin
                    st_d.idx = st_q.idx + IW'(1);
                end
            end else if (key_byte == key_at(0)) begin
                st_d.idx = IW'(1);
            end else begin
                st_d.idx = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign unlocked = st_q.open;

endmodule

// File: rtl/rpm_regs.sv
module rpm_regs
    import rpm_pkg::*;
#(
    parameter logic [7:0] MODE_PORT  = 8'h7F,
    parameter logic [7:0] UPPER_PORT = 8'hDF
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       io_wr,
    input  logic [7:0] port_hi,
    input  logic [7:0] wdata,
    input  logic       unlocked,
    output map_regs_t  regs
);
    map_regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (io_wr) begin
            if (port_hi == UPPER_PORT)
                regs_d.upper = wdata;
            if (port_hi == MODE_PORT) begin
                if (unlocked && wdata[7:5] == 3'b101) begin
                    regs_d.low_cfg = wdata[CFG_W-1:0];
                end else if (wdata[7:6] == 2'b10) begin
                    regs_d.hi_off = wdata[3];
                    regs_d.lo_off = wdata[2];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign regs = regs_q;

endmodule

// File: rtl/rpm_decode.sv
module rpm_decode
    import rpm_pkg::*;
(
    input  logic [1:0]        region,
    input  logic              mem_wr,
    input  map_regs_t         regs,
    input  logic              unlocked,
    input  logic              ext_rom_dis,
    input  logic              disk_alt,
    output logic              rom_sel,
    output logic [PAGE_W-1:0] rom_page,
    output logic              reg_page_sel,
    output logic              ram_we
);
    logic [1:0]            place;
    logic [LOW_PAGE_W-1:0] lo_pg;
    logic                  reg_on, lo_hit, hi_hit;

    always_comb begin
        reg_on = unlocked && (regs.low_cfg[4:3] == 2'b11);
        place  = (unlocked && !reg_on) ? regs.low_cfg[4:3] : 2'b00;
        lo_pg  = unlocked ? regs.low_cfg[LOW_PAGE_W-1:0] : '0;
        lo_hit = (region == place) && !regs.lo_off && !ext_rom_dis;
        hi_hit = (region == 2'b11) && !regs.hi_off && !ext_rom_dis;

        reg_page_sel = reg_on && (region == 2'b01);
        rom_sel      = lo_hit || hi_hit;
        if (lo_hit)
            rom_page = PAGE_W'(lo_pg);
        else if (hi_hit)
            rom_page = upper_phys(regs.upper, disk_alt);
        else
            rom_page = '0;
        ram_we = mem_wr && !reg_page_sel;
    end

endmodule

// File: rtl/rom_page_mapper.sv
module rom_page_mapper
    import rpm_pkg::*;
#(
    parameter logic [7:0]            MODE_PORT  = 8'h7F,
    parameter logic [7:0]            UPPER_PORT = 8'hDF,
    parameter logic [7:0]            KEY_PORT   = 8'hBC,
    parameter int                    KEY_LEN    = 4,
    parameter logic [8*KEY_LEN-1:0]  KEY        = 32'hFF00_A55A
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] cpu_addr,
    input  logic        io_wr,
    input  logic        mem_wr,
    input  logic [7:0]  cpu_data,
    input  logic        ext_rom_dis,
    input  logic        disk_alt,
    output logic        rom_sel,
    output logic [4:0]  rom_page,
    output logic        reg_page_sel,
    output logic        ram_we
);
    logic      unlocked;
    logic      key_wr;
    map_regs_t map_q;

    assign key_wr = io_wr && (cpu_addr[15:8] == KEY_PORT);

    rpm_unlock #(.KEY_LEN(KEY_LEN), .KEY(KEY)) u_unlock (
        .clk      (clk),
        .rst_n    (rst_n),
        .key_wr   (key_wr),
        .key_byte (cpu_data),
        .unlocked (unlocked)
    );

    rpm_regs #(.MODE_PORT(MODE_PORT), .UPPER_PORT(UPPER_PORT)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .io_wr    (io_wr),
        .port_hi  (cpu_addr[15:8]),
        .wdata    (cpu_data),
        .unlocked (unlocked),
        .regs     (map_q)
    );

    rpm_decode u_decode (
        .region       (cpu_addr[15:14]),
        .mem_wr       (mem_wr),
        .regs         (map_q),
        .unlocked     (unlocked),
        .ext_rom_dis  (ext_rom_dis),
        .disk_alt     (disk_alt),
        .rom_sel      (rom_sel),
        .rom_page     (rom_page),
        .reg_page_sel (reg_page_sel),
        .ram_we       (ram_we)
    );

endmodule

// File: rtl/rpm_checker.sv
module rpm_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] region,
    input logic       ext_rom_dis,
    input logic       rom_sel,
    input logic [4:0] rom_page,
    input logic       reg_page_sel,
    input logic       ram_we,
    input logic       unlocked,
    input logic [4:0] low_cfg,
    input logic [7:0] upper
);
    p_upper_fixed_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_sel && region == 2'b11 && !upper[7]) |-> (rom_page == 5'd1 || rom_page == 5'd3));

    p_upper_direct_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_sel && region == 2'b11 && upper[7]) |-> (rom_page == upper[4:0]));

    p_unlock_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        unlocked |=> unlocked);

    p_locked_cfg_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !unlocked |=> $stable(low_cfg));

    p_locked_no_regpage_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !unlocked |-> !reg_page_sel);

    p_ext_dis_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ext_rom_dis |-> !rom_sel);

    p_regpage_no_ram_r9: assert property (@(posedge clk) disable iff (!rst_n)
        reg_page_sel |-> !ram_we);

    p_page_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rom_sel |-> (rom_page == 5'd0));

endmodule

bind rom_page_mapper rpm_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .region       (cpu_addr[15:14]),
    .ext_rom_dis  (ext_rom_dis),
    .rom_sel      (rom_sel),
    .rom_page     (rom_page),
    .reg_page_sel (reg_page_sel),
    .ram_we       (ram_we),
    .unlocked     (unlocked),
    .low_cfg      (map_q.low_cfg),
    .upper        (map_q.upper)
);

// File: tb/tb_rom_page_mapper.sv
module tb_rom_page_mapper;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic        io_wr = 1'b0;
    logic        mem_wr = 1'b0;
    logic [7:0]  cpu_data = '0;
    logic        ext_rom_dis = 1'b0;
    logic        disk_alt = 1'b0;
    logic        rom_sel;
    logic [4:0]  rom_page;
    logic        reg_page_sel;
    logic        ram_we;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // bench model of the programmer-visible state
    bit       m_unl;
    bit       m_lo_off, m_hi_off;
    bit [4:0] m_cfg;
    bit [7:0] m_upper;

    always #(CLK_PERIOD/2) clk = ~clk;

    rom_page_mapper dut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .io_wr(io_wr),
        .mem_wr(mem_wr), .cpu_data(cpu_data), .ext_rom_dis(ext_rom_dis),
        .disk_alt(disk_alt), .rom_sel(rom_sel), .rom_page(rom_page),
        .reg_page_sel(reg_page_sel), .ram_we(ram_we)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_unl = 0; m_lo_off = 0; m_hi_off = 0; m_cfg = 0; m_upper = 0;
    endtask

    task automatic io_write(input bit [7:0] port, input bit [7:0] data);
        @(negedge clk);
        cpu_addr = {port, 8'h00};
        cpu_data = data;
        io_wr    = 1'b1;
        @(negedge clk);
        io_wr    = 1'b0;
        if (port == 8'hDF) m_upper = data;
        if (port == 8'h7F) begin
            if (m_unl && data[7:5] == 3'b101) m_cfg = data[4:0];
            else if (data[7:6] == 2'b10) begin
                m_hi_off = data[3];
                m_lo_off = data[2];
            end
        end
    endtask

    function automatic bit [4:0] exp_upper(input bit [7:0] s, input bit da);
        if (s >= 8'd128) return s[4:0];
        if (s == (da ? 8'd7 : 8'd0)) return 5'd3;
        return 5'd1;
    endfunction

    // probe the four 16 KB regions and compare every output
    task automatic check_regions(input string req);
        for (int r = 0; r < 4; r++) begin
            bit       regon, lo_hit, hi_hit, e_sel, e_reg;
            bit [1:0] place;
            bit [4:0] e_page;
            regon  = m_unl && m_cfg[4:3] == 2'b11;
            place  = (m_unl && !regon) ? m_cfg[4:3] : 2'b00;
            lo_hit = (r == place) && !m_lo_off && !ext_rom_dis;
            hi_hit = (r == 3) && !m_hi_off && !ext_rom_dis;
            e_sel  = lo_hit || hi_hit;
            e_reg  = regon && r == 1;
            e_page = lo_hit ? (m_unl ? {2'b00, m_cfg[2:0]} : 5'd0)
                   : hi_hit ? exp_upper(m_upper, disk_alt) : 5'd0;
            @(negedge clk);
            cpu_addr = 16'(r * 16384 + 16'h0123);
            mem_wr   = 1'b1;
            #1;
            check(rom_sel == e_sel, {req, " rom_sel"}, rom_sel, e_sel);
            check(rom_page == e_page, {req, " rom_page R10"}, rom_page, e_page);
            check(reg_page_sel == e_reg, {req, " reg_page_sel"}, reg_page_sel, e_reg);
            check(ram_we == !e_reg, {req, " ram_we R9"}, ram_we, !e_reg);
            mem_wr = 1'b0;
            #1;
            check(ram_we == 1'b0, {req, " ram_we idle R9"}, ram_we, 0);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        do_reset();
        // reset state
        check_regions("R7 R6 R8 reset");

        // R1 R2: every upper select value under both disk codes
        for (int v = 0; v < 256; v++) begin
            io_write(8'hDF, 8'(v));
            for (int d = 0; d < 2; d++) begin
                bit [4:0] e;
                @(negedge clk);
                disk_alt = d[0];
                cpu_addr = 16'hC456;
                #1;
                e = exp_upper(8'(v), d[0]);
                check(rom_sel == 1'b1, "R1 high rom_sel", rom_sel, 1);
                check(rom_page == e, v >= 128 ? "R2 direct page" : "R1 fixed page", rom_page, e);
            end
        end
        disk_alt = 1'b0;
        io_write(8'hDF, 8'h85);

        // R4 locked: secondary-looking write is a mode write (bit3 -> high off)
        io_write(8'h7F, 8'hBB);
        check_regions("R4 locked secondary write");
        io_write(8'h7F, 8'h84);          // R8 low ROM off
        check_regions("R8 low off");
        io_write(8'h7F, 8'h80);
        // R8 external disable
        ext_rom_dis = 1'b1;
        check_regions("R8 external disable");
        ext_rom_dis = 1'b0;

        // R3: wrong byte, restart on first key byte, partial key
        io_write(8'hBC, 8'h12);
        io_write(8'hBC, 8'hFF);
        io_write(8'hBC, 8'h00);
        io_write(8'hBC, 8'hFF);
        io_write(8'hBC, 8'h00);
        io_write(8'hBC, 8'hA5);
        io_write(8'h7F, 8'hBB);          // still locked: high off
        check_regions("R3 partial key stays locked");
        io_write(8'h7F, 8'h80);
        io_write(8'hBC, 8'h5A);
        m_unl = 1;
        io_write(8'hBC, 8'h33);          // further bytes ignored
        io_write(8'h7F, 8'hBD);          // now secondary: reg page on, page 5
        check_regions("R3 R5 unlocked register page");

        // R5 R6 R9: every secondary value
        for (int c = 0; c < 32; c++) begin
            io_write(8'h7F, 8'hA0 | 8'(c));
            check_regions("R5 R6 placement sweep");
        end

        // R8 legacy mode writes still work when unlocked
        io_write(8'h7F, 8'hA9);          // low bank at 4000h page 1
        io_write(8'h7F, 8'h84);
        check_regions("R8 unlocked low off");
        io_write(8'h7F, 8'h88);
        check_regions("R8 unlocked high off");
        io_write(8'h7F, 8'h80);

        // R3 reset relocks
        do_reset();
        io_write(8'h7F, 8'hB9);          // locked: mode write, high off
        check_regions("R3 reset relocks");

        finish_run();
    end

endmodule